// File: doc/BRIEF.md
# UART Register Front End

This block is the 16-bit memory-mapped register front end of a serial port. It decodes a byte address on a simple single-cycle bus into twelve word-aligned registers: the divisor pair, global control, line control, modem control, line status, modem status, scratch, the interrupt-enable set and clear windows, transmit holding and receive buffer. It does not shift bits, generate a baud rate or buffer data. A separate serial engine owns those jobs. The engine talks to this block through a transmit-load strobe, a receive-pop strobe, three live status levels and a set of one-cycle event pulses.

The interrupt enable is one internal word. It is reached through two addresses: one ORs bits in and the other clears the bits written as one. The sticky error bits in line status and the clear-to-send change bit in modem status clear only when software writes a one to them. An event from the engine in the same cycle wins over that clear. A line-status read takes the data-ready, holding-empty and transmitter-empty bits from the engine's live levels and keeps the refreshed value. The block rejects a bad access (wrong width, misaligned or unmapped address, or read and write together) with an error pulse and changes nothing.

Top module: `uart_regfile`

## Requirements
- R1: After reset, reads return 0x0001 for the divisor-low register (index 0) and zero for all other stored registers. Line status reads 0x0060 when the live data-ready input is 0 and holding-empty and transmitter-empty are 1. No strobe or error is active.
- R2: Register index i sits at byte address 4*i. The storage order is divisor low 0, divisor high 1, global control 2, line control 3, modem control 4, line status 5, modem status 6, scratch 7, enable set 8, enable clear 9, transmit holding 10, receive buffer 11. Indices 0 to 4 and 7 read back the full 16-bit value last written to them.
- R3: A write to index 8 ORs the written data into the interrupt-enable word.
- R4: A write to index 9 clears every interrupt-enable bit that is written as one and leaves the bits written as zero unchanged.
- R5: A read of index 8 or index 9 returns the current interrupt-enable word.
- R6: The line-status sticky bits are overrun (bit 1), parity (bit 2), framing (bit 3), break (bit 4) and transmit-done (bit 7). Each is set by its own event pulse and cleared only by a write of one to index 5. A write changes no other line-status bit. An event in the same cycle as a clearing write leaves its bit set.
- R7: Modem-status bit 0 is set by the clear-to-send change pulse and cleared only by writing one to that bit of index 6. Writes to the other bits of index 6 have no effect.
- R8: A line-status read returns bit 0 = live data-ready, bit 5 = live holding-empty and bit 6 = live transmitter-empty, merged with the sticky bits.
- R9: A write to index 11 is ignored: it raises no receive pop, no error, and changes no register.
- R10: A write to index 10 latches the low byte, which then reads back zero-extended and drives the transmit byte output. It also pulses the transmit-load strobe for one cycle after the write. The transmit-interrupt strobe pulses with it only if interrupt-enable bit 1 is set.
- R11: A read of index 11 returns the receive byte input present with the request, zero-extended, and pulses the receive-pop strobe for one cycle.
- R12: An access of a width code other than 1 (16-bit), an address with a nonzero low two bits or with index 12 or above, or one asserting read and write together pulses the error output for one cycle. Such an access changes no state, pulses no strobe and loads zero into the read data on a read.
- R13: Read data appears in the cycle after the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write request, one cycle |
| bus_rd | input | 1 | Read request, one cycle |
| bus_size | input | 2 | Access width code (0 byte, 1 half-word, 2 word) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | Access-error pulse, one cycle after a bad access |
| core_dr | input | 1 | Live receive-data-ready level |
| core_thre | input | 1 | Live transmit-holding-empty level |
| core_temt | input | 1 | Live transmitter-empty level |
| evt_overrun | input | 1 | Overrun event pulse |
| evt_parity | input | 1 | Parity error event pulse |
| evt_framing | input | 1 | Framing error event pulse |
| evt_break | input | 1 | Break detected event pulse |
| evt_txdone | input | 1 | Transmit finished event pulse |
| evt_cts | input | 1 | Clear-to-send change event pulse |
| rx_byte | input | 8 | Next received byte from the engine |
| rx_pop | output | 1 | Consume strobe toward the receive side |
| tx_byte | output | 8 | Latched transmit byte |
| tx_load | output | 1 | Transmit-data strobe |
| tx_irq | output | 1 | Transmit interrupt event pulse |

## Verification
A wrong address decode or a lost enable bit shows one cycle after the offending access, on the read data of the next read, on a strobe that fires or stays quiet, or on the error pulse. A sticky bit that clears without a one written, or a live bit taken from a stale copy, shows on the very next line-status read. The bench sweeps every byte address and width code, every event-mask combination and every live-status combination. An error in any of them therefore shows within two cycles of the access that caused it.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam int NREG = 12;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [3:0] {
    RG_DIVLO   = 4'd0,
    RG_DIVHI   = 4'd1,
    RG_GCTL    = 4'd2,
    RG_LINE    = 4'd3,
    RG_MODEM   = 4'd4,
    RG_LSTAT   = 4'd5,
    RG_MSTAT   = 4'd6,
    RG_SCRATCH = 4'd7,
    RG_IESET   = 4'd8,
    RG_IECLR   = 4'd9,
    RG_TXHOLD  = 4'd10,
    RG_RXBUF   = 4'd11
  } reg_idx_e;

  // line status bit positions
  localparam int LS_DR    = 0;
  localparam int LS_OVR   = 1;
  localparam int LS_PAR   = 2;
  localparam int LS_FRM   = 3;
  localparam int LS_BRK   = 4;
  localparam int LS_THRE  = 5;
  localparam int LS_TEMT  = 6;
  localparam int LS_TXD   = 7;
  localparam int MS_DCTS  = 0;
  localparam int IE_TXE   = 1;

  localparam logic [15:0] LS_STICKY = 16'h009E;
  localparam logic [15:0] MS_STICKY = 16'h0001;
  localparam logic [15:0] LS_RESET  = 16'h0060;
  localparam logic [15:0] DIV_RESET = 16'h0001;

  localparam int NPLAIN = 6;

  // register index held by plain storage slot k
  function automatic int plain_idx(input int k);
    case (k)
      0: plain_idx = 0;
      1: plain_idx = 1;
      2: plain_idx = 2;
      3: plain_idx = 3;
      4: plain_idx = 4;
      default: plain_idx = 7;
    endcase
  endfunction

  // clear the masked bits written as one
  function automatic logic [15:0] w1c(input logic [15:0] cur,
                                      input logic [15:0] wd,
                                      input logic [15:0] mask);
    w1c = cur & ~(wd & mask);
  endfunction

  // overwrite the three live line bits
  function automatic logic [15:0] lsr_refresh(input logic [15:0] cur,
                                              input logic dr,
                                              input logic thre,
                                              input logic temt);
    logic [15:0] r;
    r = cur;
    r[LS_DR]   = dr;
    r[LS_THRE] = thre;
    r[LS_TEMT] = temt;
    lsr_refresh = r;
  endfunction

endpackage

// File: rtl/uart_bus_decode.sv
module uart_bus_decode
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        size,
  output logic [NREG-1:0]   sel,
  output reg_idx_e          idx,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              bad
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word;
  logic             aligned;
  logic             in_range;
  logic             size_ok;
  logic             legal;

  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (word < IDX_W'(NREG));
  assign size_ok  = (size == SZ_HALF);
  assign legal    = aligned && in_range && size_ok;
  assign idx      = reg_idx_e'(word[3:0]);

  assign wr_ok = wr && !rd && legal;
  assign rd_ok = rd && !wr && legal;
  assign bad   = (wr || rd) && (!legal || (wr && rd));

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign sel[i] = legal && (word == IDX_W'(i));
  end
endmodule

// File: rtl/uart_store_reg.sv
module uart_store_reg #(
  parameter int          W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= d;
  end
endmodule

// File: rtl/uart_irq_en.sv
module uart_irq_en
  import uart_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_we,
  input  logic        clr_we,
  input  logic [15:0] wdata,
  output logic [15:0] ier_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ier_q <= '0;
    else if (set_we) ier_q <= ier_q | wdata;
    else if (clr_we) ier_q <= w1c(ier_q, wdata, 16'hFFFF);
  end
endmodule

// File: rtl/uart_status_regs.sv
module uart_status_regs
  import uart_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lsr_we,
  input  logic        lsr_rd,
  input  logic        msr_we,
  input  logic [15:0] wdata,
  input  logic        core_dr,
  input  logic        core_thre,
  input  logic        core_temt,
  input  logic        evt_overrun,
  input  logic        evt_parity,
  input  logic        evt_framing,
  input  logic        evt_break,
  input  logic        evt_txdone,
  input  logic        evt_cts,
  output logic [15:0] lsr_q,
  output logic [15:0] lsr_view,
  output logic [15:0] msr_q
);
  logic [15:0] ls_set;
  logic [15:0] ms_set;
  logic [15:0] lsr_next;
  logic [15:0] msr_next;

  always_comb begin
    ls_set = '0;
    ls_set[LS_OVR] = evt_overrun;
    ls_set[LS_PAR] = evt_parity;
    ls_set[LS_FRM] = evt_framing;
    ls_set[LS_BRK] = evt_break;
    ls_set[LS_TXD] = evt_txdone;
    ms_set = '0;
    ms_set[MS_DCTS] = evt_cts;
  end

  assign lsr_view = lsr_refresh(lsr_q, core_dr, core_thre, core_temt);

  always_comb begin
    lsr_next = lsr_q;
    if (lsr_rd) lsr_next = lsr_view;
    if (lsr_we) lsr_next = w1c(lsr_next, wdata, LS_STICKY);
    lsr_next = lsr_next | ls_set;
    msr_next = msr_q;
    if (msr_we) msr_next = w1c(msr_next, wdata, MS_STICKY);
    msr_next = msr_next | ms_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsr_q <= LS_RESET;
      msr_q <= '0;
    end else begin
      lsr_q <= lsr_next;
      msr_q <= msr_next;
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_err,
  input  logic              core_dr,
  input  logic              core_thre,
  input  logic              core_temt,
  input  logic              evt_overrun,
  input  logic              evt_parity,
  input  logic              evt_framing,
  input  logic              evt_break,
  input  logic              evt_txdone,
  input  logic              evt_cts,
  input  logic [7:0]        rx_byte,
  output logic              rx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_load,
  output logic              tx_irq
);
  logic [NREG-1:0] sel;
  reg_idx_e        idx;
  logic            wr_ok;
  logic            rd_ok;
  logic            acc_bad;

  // named internal events for the checker
  logic            ev_thr_wr;
  logic            ev_rbr_rd;
  logic            ev_ier_set;
  logic            ev_ier_clr;

  logic [15:0]     ier_q;
  logic [15:0]     lsr_q;
  logic [15:0]     lsr_view;
  logic [15:0]     msr_q;
  logic [7:0]      thr_q;
  logic [15:0]     plain_q [NPLAIN];
  logic [15:0]     rd_mux;

  uart_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (bus_addr),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .size  (bus_size),
    .sel   (sel),
    .idx   (idx),
    .wr_ok (wr_ok),
    .rd_ok (rd_ok),
    .bad   (acc_bad)
  );

  assign ev_thr_wr  = wr_ok && sel[RG_TXHOLD];
  assign ev_rbr_rd  = rd_ok && sel[RG_RXBUF];
  assign ev_ier_set = wr_ok && sel[RG_IESET];
  assign ev_ier_clr = wr_ok && sel[RG_IECLR];

  for (genvar k = 0; k < NPLAIN; k++) begin : g_plain
    localparam int RI = plain_idx(k);
    uart_store_reg #(
      .W   (16),
      .RST ((RI == 0) ? DIV_RESET : 16'h0000)
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_ok && sel[RI]),
      .d     (bus_wdata),
      .q     (plain_q[k])
    );
  end

  uart_irq_en u_ier (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (ev_ier_set),
    .clr_we (ev_ier_clr),
    .wdata  (bus_wdata),
    .ier_q  (ier_q)
  );

  uart_status_regs u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .lsr_we      (wr_ok && sel[RG_LSTAT]),
    .lsr_rd      (rd_ok && sel[RG_LSTAT]),
    .msr_we      (wr_ok && sel[RG_MSTAT]),
    .wdata       (bus_wdata),
    .core_dr     (core_dr),
    .core_thre   (core_thre),
    .core_temt   (core_temt),
    .evt_overrun (evt_overrun),
    .evt_parity  (evt_parity),
    .evt_framing (evt_framing),
    .evt_break   (evt_break),
    .evt_txdone  (evt_txdone),
    .evt_cts     (evt_cts),
    .lsr_q       (lsr_q),
    .lsr_view    (lsr_view),
    .msr_q       (msr_q)
  );

  uart_store_reg #(.W(8), .RST(8'h00)) u_thr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ev_thr_wr),
    .d     (bus_wdata[7:0]),
    .q     (thr_q)
  );

  assign tx_byte = thr_q;

  always_comb begin
    case (idx)
      RG_DIVLO:   rd_mux = plain_q[0];
      RG_DIVHI:   rd_mux = plain_q[1];
      RG_GCTL:    rd_mux = plain_q[2];
      RG_LINE:    rd_mux = plain_q[3];
      RG_MODEM:   rd_mux = plain_q[4];
      RG_SCRATCH: rd_mux = plain_q[5];
      RG_LSTAT:   rd_mux = lsr_view;
      RG_MSTAT:   rd_mux = msr_q;
      RG_IESET,
      RG_IECLR:   rd_mux = ier_q;
      RG_TXHOLD:  rd_mux = {8'h00, thr_q};
      RG_RXBUF:   rd_mux = {8'h00, rx_byte};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      tx_load   <= 1'b0;
      tx_irq    <= 1'b0;
      rx_pop    <= 1'b0;
    end else begin
      if (rd_ok)       bus_rdata <= rd_mux;
      else if (bus_rd) bus_rdata <= '0;
      bus_err <= acc_bad;
      tx_load <= ev_thr_wr;
      tx_irq  <= ev_thr_wr && ier_q[IE_TXE];
      rx_pop  <= ev_rbr_rd;
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int ADDR_W = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] bus_wdata,
  input logic        bus_err,
  input logic        tx_load,
  input logic        tx_irq,
  input logic        rx_pop,
  input logic [15:0] ier_q,
  input logic        ev_thr_wr,
  input logic        ev_rbr_rd,
  input logic        ev_ier_set,
  input logic        ev_ier_clr
);
  // R10
  thr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_thr_wr |=> tx_load);

  // R10
  tx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tx_load && ier_q[1]));

  // R3
  ier_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ier_set |=> ((ier_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  ier_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ier_clr |=> ((ier_q & $past(bus_wdata)) == 16'h0000));

  // R11
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rbr_rd |=> rx_pop);

  // R11
  rx_pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(bus_rd && !bus_wr));

  // R12
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!tx_load && !rx_pop && !tx_irq));
endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_err    (bus_err),
  .tx_load    (tx_load),
  .tx_irq     (tx_irq),
  .rx_pop     (rx_pop),
  .ier_q      (ier_q),
  .ev_thr_wr  (ev_thr_wr),
  .ev_rbr_rd  (ev_rbr_rd),
  .ev_ier_set (ev_ier_set),
  .ev_ier_clr (ev_ier_clr)
);

// File: tb/uart_regfile_test.sv
`timescale 1ns/1ps
module uart_regfile_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wr, bus_rd;
  logic [1:0]    bus_size;
  logic [15:0]   bus_wdata, bus_rdata;
  logic          bus_err;
  logic          core_dr, core_thre, core_temt;
  logic          evt_overrun, evt_parity, evt_framing, evt_break, evt_txdone, evt_cts;
  logic [7:0]    rx_byte, tx_byte;
  logic          rx_pop, tx_load, tx_irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] r_data;
  logic        r_err, r_pop, r_load, r_irq;

  always #4 clk = ~clk;

  uart_regfile #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .core_dr(core_dr),
    .core_thre(core_thre), .core_temt(core_temt), .evt_overrun(evt_overrun),
    .evt_parity(evt_parity), .evt_framing(evt_framing), .evt_break(evt_break),
    .evt_txdone(evt_txdone), .evt_cts(evt_cts), .rx_byte(rx_byte),
    .rx_pop(rx_pop), .tx_byte(tx_byte), .tx_load(tx_load), .tx_irq(tx_irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sample();
    r_data = bus_rdata; r_err = bus_err; r_pop = rx_pop;
    r_load = tx_load;   r_irq = tx_irq;
  endtask

  task automatic acc(input bit w, input bit r, input logic [AW-1:0] a,
                     input logic [15:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    sample();
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    acc(1'b1, 1'b0, AW'(idx * 4), d, 2'd1);
  endtask

  task automatic rd(input int idx);
    acc(1'b0, 1'b1, AW'(idx * 4), 16'h0, 2'd1);
  endtask

  function automatic logic [15:0] sticky_of(input logic [4:0] m);
    // m = {txdone, break, framing, parity, overrun}
    sticky_of = 16'((m[3:0] << 1) | (m[4] << 7));
  endfunction

  function automatic logic [15:0] live_of(input bit dr, input bit th, input bit te);
    live_of = 16'(dr) | (16'(th) << 5) | (16'(te) << 6);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] ier_m, lsr_s, exp_v, v;
    logic [15:0] plain_m [6];
    int plain_i [6];
    plain_i = '{0, 1, 2, 3, 4, 7};

    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_size = 2'd1;
    bus_wdata = '0; core_dr = 0; core_thre = 1; core_temt = 1;
    evt_overrun = 0; evt_parity = 0; evt_framing = 0; evt_break = 0;
    evt_txdone = 0; evt_cts = 0; rx_byte = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset values
    sample();
    check(!r_err && !r_pop && !r_load && !r_irq, "R1 strobes idle", {r_err, r_pop, r_load, r_irq}, 0);
    for (int i = 0; i < 11; i++) begin
      rd(i);
      exp_v = (i == 0) ? 16'h0001 : (i == 5) ? 16'h0060 : 16'h0000;
      check(r_data == exp_v && !r_err, "R1 reset read", r_data, exp_v);
    end

    // R2 plain storage sweep
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 6; k++) begin
        plain_m[k] = 16'(16'hA5C3 ^ (p * 16'h3131) ^ (k * 16'h0F11));
        wr(plain_i[k], plain_m[k]);
      end
      for (int k = 0; k < 6; k++) begin
        rd(plain_i[k]);
        check(r_data == plain_m[k], "R2 plain readback", r_data, plain_m[k]);
      end
    end

    // R3 R4 R5 enable set/clear sweep
    ier_m = 16'h0000;
    for (int i = 0; i < 32; i++) begin
      v = 16'((i * 16'h3B5D) ^ 16'h1234);
      if (i % 2 == 0) begin wr(8, v); ier_m = ier_m | v; end
      else begin wr(9, v); ier_m = ier_m & ~v; end
      rd(8 + (i % 2));
      check(r_data == ier_m, (i % 2 == 0) ? "R3 set then R5 read" : "R4 clear then R5 read", r_data, ier_m);
    end
    wr(9, 16'hFFFF); ier_m = 16'h0000;
    rd(8);
    check(r_data == 16'h0000, "R4 clear all", r_data, 16'h0000);

    // R6 sticky line bits over all event masks
    for (int m = 0; m < 32; m++) begin
      @(negedge clk);
      {evt_txdone, evt_break, evt_framing, evt_parity, evt_overrun} = 5'(m);
      @(negedge clk);
      {evt_txdone, evt_break, evt_framing, evt_parity, evt_overrun} = 5'b0;
      lsr_s = sticky_of(5'(m));
      rd(5);
      check(r_data == (lsr_s | 16'h0060), "R6 sticky set", r_data, lsr_s | 16'h0060);
      v = 16'((m * 16'h4D2B) ^ 16'hFF61);
      wr(5, v);
      lsr_s = lsr_s & ~(v & 16'h009E);
      rd(5);
      check(r_data == (lsr_s | 16'h0060), "R6 w1c", r_data, lsr_s | 16'h0060);
      wr(5, 16'hFFFF);
      lsr_s = 16'h0000;
    end
    // R6 event beats a clear in the same cycle
    @(negedge clk);
    bus_addr = AW'(20); bus_wr = 1; bus_wdata = 16'hFFFF; bus_size = 2'd1;
    evt_overrun = 1; evt_break = 1;
    @(negedge clk);
    bus_wr = 0; evt_overrun = 0; evt_break = 0;
    rd(5);
    check(r_data == 16'h0072, "R6 event wins over clear", r_data, 16'h0072);
    wr(5, 16'h00FF);

    // R7 modem status change bit
    @(negedge clk); evt_cts = 1;
    @(negedge clk); evt_cts = 0;
    rd(6);
    check(r_data == 16'h0001, "R7 set", r_data, 16'h0001);
    wr(6, 16'hFFFE);
    rd(6);
    check(r_data == 16'h0001, "R7 zero write keeps", r_data, 16'h0001);
    wr(6, 16'h0001);
    rd(6);
    check(r_data == 16'h0000, "R7 one write clears", r_data, 16'h0000);

    // R8 live status merge over all combinations
    @(negedge clk); evt_parity = 1;
    @(negedge clk); evt_parity = 0;
    for (int c = 0; c < 8; c++) begin
      core_dr = c[0]; core_thre = c[1]; core_temt = c[2];
      rd(5);
      exp_v = live_of(c[0], c[1], c[2]) | 16'h0004;
      check(r_data == exp_v, "R8 live merge", r_data, exp_v);
    end
    core_dr = 0; core_thre = 1; core_temt = 1;
    wr(5, 16'h0004);

    // R9 write to receive buffer ignored
    wr(7, 16'h5A5A);
    wr(11, 16'hFFFF);
    check(!r_pop && !r_err && !r_load, "R9 no strobe", {r_pop, r_err, r_load}, 0);
    rd(7);
    check(r_data == 16'h5A5A, "R9 scratch untouched", r_data, 16'h5A5A);
    rd(10);
    check(r_data == 16'h0000, "R9 hold untouched", r_data, 16'h0000);

    // R10 transmit writes with and without the enable
    wr(10, 16'hBE3C);
    check(r_load && !r_irq, "R10 load no irq", {r_load, r_irq}, 2'b10);
    check(tx_byte == 8'h3C, "R10 tx byte", tx_byte, 8'h3C);
    @(negedge clk);
    check(!tx_load, "R10 one-cycle load", tx_load, 0);
    wr(8, 16'h0002);
    wr(10, 16'h00E7);
    check(r_load && r_irq, "R10 load with irq", {r_load, r_irq}, 2'b11);
    rd(10);
    check(r_data == 16'h00E7, "R10 readback", r_data, 16'h00E7);
    wr(9, 16'h0002);

    // R11 receive reads
    for (int b = 0; b < 8; b++) begin
      rx_byte = 8'((b * 8'h37) ^ 8'hC5);
      rd(11);
      check(r_data == {8'h00, rx_byte} && r_pop, "R11 rx read", {r_pop, r_data}, {1'b1, 8'h00, rx_byte});
      @(negedge clk);
      check(!rx_pop, "R11 one-cycle pop", rx_pop, 0);
    end

    // R13 read data holds between reads
    wr(7, 16'h1357);
    rd(7);
    repeat (3) @(negedge clk);
    check(bus_rdata == 16'h1357, "R13 hold", bus_rdata, 16'h1357);

    // R12 full address sweep
    for (int a = 0; a < 256; a++) begin
      bit legal;
      legal = (a % 4 == 0) && (a / 4 < 12);
      acc(1'b0, 1'b1, AW'(a), 16'h0, 2'd1);
      check(r_err == !legal, "R12 address decode", r_err, !legal);
      if (!legal) check(r_data == 16'h0000 && !r_pop, "R12 bad read zero", r_data, 0);
    end
    // R12 width codes and bad writes leave state
    for (int s = 0; s < 4; s++) begin
      acc(1'b1, 1'b0, AW'(0), 16'hDEAD, 2'(s));
      check(r_err == (s != 1), "R12 width", r_err, s != 1);
      if (s == 1) plain_m[0] = 16'hDEAD;
    end
    acc(1'b1, 1'b0, AW'(1), 16'hBEEF, 2'd1);
    check(r_err, "R12 misaligned write", r_err, 1);
    acc(1'b1, 1'b1, AW'(40), 16'hBEEF, 2'd1);
    check(r_err && !r_load, "R12 read and write together", {r_err, r_load}, 2'b10);
    acc(1'b1, 1'b0, AW'(48), 16'hBEEF, 2'd1);
    check(r_err, "R12 unmapped write", r_err, 1);
    rd(0);
    check(r_data == 16'hDEAD, "R12 no state change", r_data, 16'hDEAD);
    rd(10);
    check(r_data == 16'h00E7, "R12 hold unchanged", r_data, 16'h00E7);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule